// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers I2C transactions carried over a display auxiliary channel without driving any physical signalling. Software writes a request word into a data register and then writes the control register with its send-busy bit set. In the same cycle the block decodes the request, updates its target-selection state and writes a synthesized reply back into both registers. The control register then reads back with send-busy cleared and a done flag set, so a polling driver sees at once that the request has completed.

Three request kinds are handled. The first is an address-only start or stop, which opens, restarts or closes a transaction. The second is a write, which is acknowledged and otherwise ignored. The third is a single-byte read, which returns the next byte from a shared EDID byte source. The block drives a port index and a read pointer into that source and receives one byte back combinationally. Whether a middle-of-transaction (MOT) sequence is open persists across messages. Reads that cannot be served return 0xFF.

Top module: `aux_edid_responder`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `edid_ptr` is zero and both `i2c_active` and `mot_active` are low.
- R2: A write to any register index other than 0 (control) stores the word, which reads back unchanged. It leaves the pointer, the flags and the other registers untouched.
- R3: A control write with bit 31 (send-busy) clear is stored exactly as written and starts no processing: the data register (index 1), the pointer and the flags keep their values.
- R4: A control write with bit 31 set is stored with bit 31 cleared, bit 30 (done) set and the size field in bits 24:20 replaced by the reply size. The reply size is 2 when bit 0 of the request opcode (read) is set and 1 otherwise. All other bits are kept as written.
- R5: The request is taken from the data register: target address in bits 23:8, command byte in bits 31:24, opcode in the command byte's upper nibble. The message length is the size field (bits 24:20) of the control word being written. A length-3 request whose opcode bit 2 (MOT) is clear is a stop: it clears the selection, the availability, the pointer and both flags, and the data register becomes `{ACK_CODE, 24'h0}`.
- R6: A length-3 request with MOT set raises `i2c_active` and `mot_active`. If its address is 0, it also clears the pointer, the selection and the availability. The data register becomes `{ACK_CODE, 24'h0}`.
- R7: A length-3 request with MOT set and address `EDID_ADDR` (default 0x0050) selects the target and copies `port_id` onto `edid_port`. It marks EDID available only when both `port_is_dp` and `monitor_present` are high for that port.
- R8: A request with opcode bit 0 clear and a length other than 3 is a write. It is acknowledged (data register becomes `{ACK_CODE, 24'h0}`), its data is ignored, and the pointer and flags are unchanged.
- R9: A read request (opcode bit 0 set) of length 4 is served when the target is selected, EDID is available and the pointer is below `EDID_BYTES`. In that case the data register becomes `{ACK_CODE, edid_byte, 16'h0}`, with the byte taken at the current pointer, and the pointer advances by one.
- R10: A length-4 read that cannot be served returns 0xFF in bits 23:16 and leaves the pointer unchanged.
- R11: A read request whose length is neither 3 nor 4 leaves the data register and the pointer unchanged. The control register still completes as in R4.
- R12: `i2c_active` and `mot_active` keep their values across reads and writes and change only on length-3 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index (0 control, 1 data, others stored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| port_id | input | PORT_W | Port this channel belongs to |
| port_is_dp | input | NPORTS | Per-port flag: port is a DP port |
| monitor_present | input | NPORTS | Per-port flag: monitor attached |
| edid_port | output | PORT_W | Port recorded at target selection |
| edid_ptr | output | PTR_W | EDID read pointer |
| edid_byte | input | 8 | EDID byte at `edid_port`/`edid_ptr` |
| i2c_active | output | 1 | Transaction opened over the channel |
| mot_active | output | 1 | Middle-of-transaction held |

## Verification
A served read does two things on the same clock edge: it captures the byte that the source presents at the current pointer into the data register, and it advances that pointer. A bench source model that depends on both the port and the pointer exposes any skipped, repeated or wrong-port byte. Runs of reads longer than the EDID region are swept for every port and every DP/monitor combination, with the other ports given the opposite flags. Each returned byte is compared with the arithmetic model at the read's index, and the pointer is compared with min(index+1, EDID_BYTES). The point where capture and increment stop together, at the end of the region, is judged by requiring 0xFF and a frozen pointer.

// File: rtl/aux_edid_pkg.sv
// Shared field positions and request classification for the AUX EDID responder.
// Assumes a 32-bit register port; bit positions are fixed by the software view.
package aux_edid_pkg;
    localparam int CTL_IDX        = 0;
    localparam int DATA_IDX       = 1;
    localparam int CTL_BUSY_BIT   = 31;
    localparam int CTL_DONE_BIT   = 30;
    localparam int CTL_SIZE_LSB   = 20;
    localparam int CTL_SIZE_W     = 5;
    localparam int REQ_ADDR_LSB   = 8;
    localparam int REQ_CMD_LSB    = 24;
    localparam int OP_READ_BIT    = 0;
    localparam int OP_MOT_BIT     = 2;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STOP,
        ACT_START,
        ACT_WRITE,
        ACT_READ,
        ACT_BADREAD
    } act_e;
endpackage

// File: rtl/aux_req_decode.sv
// Classifies a control write into one request action.
// Assumes the request word already sits in the data register when the
// control register is written with send-busy set.
module aux_req_decode
    import aux_edid_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       data_q,
    output logic              go,
    output act_e              act,
    output logic [15:0]       tgt_addr,
    output logic [CTL_SIZE_W-1:0] reply_size
);
    logic [CTL_SIZE_W-1:0] msg_len;
    logic [7:0]            cmd;
    logic [3:0]            op;

    // Pick out the request fields and the trigger condition.
    always_comb begin
        go         = reg_wr && (reg_addr == ADDR_W'(CTL_IDX)) && reg_wdata[CTL_BUSY_BIT];
        msg_len    = reg_wdata[CTL_SIZE_LSB +: CTL_SIZE_W];
        cmd        = data_q[REQ_CMD_LSB +: 8];
        op         = cmd[7:4];
        tgt_addr   = data_q[REQ_ADDR_LSB +: 16];
        reply_size = op[OP_READ_BIT] ? CTL_SIZE_W'(2) : CTL_SIZE_W'(1);
    end

    // Map length and opcode to an action; address-only wins over opcode.
    always_comb begin
        act = ACT_NONE;
        if (go) begin
            if (msg_len == CTL_SIZE_W'(3))
                act = op[OP_MOT_BIT] ? ACT_START : ACT_STOP;
            else if (!op[OP_READ_BIT])
                act = ACT_WRITE;
            else if (msg_len == CTL_SIZE_W'(4))
                act = ACT_READ;
            else
                act = ACT_BADREAD;
        end
    end
endmodule

// File: rtl/aux_edid_state.sv
// Holds the transaction state: target selection, EDID availability, the
// recorded port, the read pointer and the open/MOT flags.
// Assumes edid_byte is a combinational function of edid_port and edid_ptr.
module aux_edid_state
    import aux_edid_pkg::*;
#(
    parameter int          NPORTS     = 4,
    parameter int          PORT_W     = 2,
    parameter int          EDID_BYTES = 128,
    parameter int          PTR_W      = 8,
    parameter logic [15:0] EDID_ADDR  = 16'h0050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [15:0]       tgt_addr,
    input  logic [PORT_W-1:0] port_id,
    input  logic [NPORTS-1:0] port_is_dp,
    input  logic [NPORTS-1:0] monitor_present,
    input  logic [7:0]        edid_byte,
    output logic [PORT_W-1:0] edid_port,
    output logic [PTR_W-1:0]  edid_ptr,
    output logic              i2c_active,
    output logic              mot_active,
    output logic [7:0]        reply_byte
);
    logic sel_q;
    logic avail_q;
    logic can_read;
    logic port_ok;
    logic port_has_edid;

    // Decide whether a read can be served and what byte it returns.
    always_comb begin
        port_ok       = int'(port_id) < NPORTS;
        port_has_edid = port_ok && port_is_dp[port_id] && monitor_present[port_id];
        can_read      = sel_q && avail_q && (edid_ptr < PTR_W'(EDID_BYTES));
        reply_byte    = can_read ? edid_byte : 8'hFF;
    end

    // Advance the selection, pointer and flags on each processed request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= 1'b0;
            avail_q    <= 1'b0;
            edid_ptr   <= '0;
            edid_port  <= '0;
            i2c_active <= 1'b0;
            mot_active <= 1'b0;
        end else begin
            case (act)
                ACT_STOP: begin
                    sel_q      <= 1'b0;
                    avail_q    <= 1'b0;
                    edid_ptr   <= '0;
                    i2c_active <= 1'b0;
                    mot_active <= 1'b0;
                end
                ACT_START: begin
                    i2c_active <= 1'b1;
                    mot_active <= 1'b1;
                    if (tgt_addr == 16'h0000) begin
                        sel_q    <= 1'b0;
                        avail_q  <= 1'b0;
                        edid_ptr <= '0;
                    end else if (tgt_addr == EDID_ADDR) begin
                        sel_q     <= 1'b1;
                        edid_port <= port_id;
                        avail_q   <= port_has_edid;
                    end
                end
                ACT_READ: begin
                    if (can_read)
                        edid_ptr <= edid_ptr + PTR_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aux_reg_file.sv
// Channel register file: control, data and plain storage registers.
// Control and data take the synthesized reply when a request is processed.
// Assumes NUM_REGS >= 2 (control at index 0, data at index 1).
module aux_reg_file
    import aux_edid_pkg::*;
#(
    parameter int         NUM_REGS = 5,
    parameter int         ADDR_W   = 3,
    parameter logic [7:0] ACK_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              go,
    input  act_e              act,
    input  logic [CTL_SIZE_W-1:0] reply_size,
    input  logic [7:0]        reply_byte,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       ctl_q,
    output logic [31:0]       data_q
);
    logic [31:0] regs_rd [NUM_REGS];
    logic [31:0] ctl_done_word;
    logic [31:0] reply_word;
    logic        reply_wr;

    // Build the completed control word and the ack-plus-data reply.
    always_comb begin
        ctl_done_word = reg_wdata;
        ctl_done_word[CTL_BUSY_BIT] = 1'b0;
        ctl_done_word[CTL_DONE_BIT] = 1'b1;
        ctl_done_word[CTL_SIZE_LSB +: CTL_SIZE_W] = reply_size;
        reply_word = {ACK_CODE, (act == ACT_READ) ? reply_byte : 8'h00, 16'h0000};
        reply_wr   = go && (act != ACT_BADREAD) && (act != ACT_NONE);
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [31:0] q;
        logic        hit;
        assign hit        = reg_wr && (reg_addr == ADDR_W'(i));
        assign regs_rd[i] = q;

        if (i == CTL_IDX) begin : g_ctl
            // Control: store completion word on busy writes, else verbatim.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (hit)
                    q <= reg_wdata[CTL_BUSY_BIT] ? ctl_done_word : reg_wdata;
            end
        end else if (i == DATA_IDX) begin : g_data
            // Data: software writes, or the reply word after processing.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (hit)
                    q <= reg_wdata;
                else if (reply_wr)
                    q <= reply_word;
            end
        end else begin : g_plain
            // Other channel registers: plain storage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (hit)
                    q <= reg_wdata;
            end
        end
    end

    assign ctl_q  = regs_rd[CTL_IDX];
    assign data_q = regs_rd[DATA_IDX];

    // Read mux; indices beyond the file read zero.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_REGS)
            reg_rdata = regs_rd[reg_addr];
    end
endmodule

// File: rtl/aux_edid_responder.sv
// Top of the I2C-over-AUX EDID responder. Decodes a request when the control
// register is written with send-busy, updates transaction state and writes
// the reply back in the same cycle. Assumes an external EDID byte source
// indexed by edid_port and edid_ptr that answers combinationally.
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          NPORTS     = 4,
    parameter int          EDID_BYTES = 128,
    parameter int          NUM_REGS   = 5,
    parameter logic [15:0] EDID_ADDR  = 16'h0050,
    parameter logic [7:0]  ACK_CODE   = 8'h00,
    localparam int         PORT_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int         PTR_W      = $clog2(EDID_BYTES) + 1,
    localparam int         ADDR_W     = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PORT_W-1:0] port_id,
    input  logic [NPORTS-1:0] port_is_dp,
    input  logic [NPORTS-1:0] monitor_present,
    output logic [PORT_W-1:0] edid_port,
    output logic [PTR_W-1:0]  edid_ptr,
    input  logic [7:0]        edid_byte,
    output logic              i2c_active,
    output logic              mot_active
);
    logic                  go;
    act_e                  act;
    logic [15:0]           tgt_addr;
    logic [CTL_SIZE_W-1:0] reply_size;
    logic [7:0]            reply_byte;
    logic [31:0]           ctl_q;
    logic [31:0]           data_q;

    aux_req_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .data_q     (data_q),
        .go         (go),
        .act        (act),
        .tgt_addr   (tgt_addr),
        .reply_size (reply_size)
    );

    aux_edid_state #(
        .NPORTS     (NPORTS),
        .PORT_W     (PORT_W),
        .EDID_BYTES (EDID_BYTES),
        .PTR_W      (PTR_W),
        .EDID_ADDR  (EDID_ADDR)
    ) u_state (
        .clk             (clk),
        .rst_n           (rst_n),
        .act             (act),
        .tgt_addr        (tgt_addr),
        .port_id         (port_id),
        .port_is_dp      (port_is_dp),
        .monitor_present (monitor_present),
        .edid_byte       (edid_byte),
        .edid_port       (edid_port),
        .edid_ptr        (edid_ptr),
        .i2c_active      (i2c_active),
        .mot_active      (mot_active),
        .reply_byte      (reply_byte)
    );

    aux_reg_file #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .ACK_CODE (ACK_CODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .go         (go),
        .act        (act),
        .reply_size (reply_size),
        .reply_byte (reply_byte),
        .reg_rdata  (reg_rdata),
        .ctl_q      (ctl_q),
        .data_q     (data_q)
    );
endmodule

// File: rtl/aux_edid_checker.sv
// Temporal checks on the responder, attached by bind below.
// Assumes the control register sits at index 0.
module aux_edid_checker #(
    parameter int ADDR_W     = 3,
    parameter int PTR_W      = 8,
    parameter int EDID_BYTES = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       ctl_q,
    input logic [PTR_W-1:0]  edid_ptr,
    input logic              i2c_active,
    input logic              mot_active
);
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[31]) |=> (!ctl_q[31] && ctl_q[30])); // R4

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[31]) |=> (ctl_q[24:20] == 5'd1 || ctl_q[24:20] == 5'd2)); // R4

    AST_NONCTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != '0) |=> ($stable(edid_ptr) && $stable(i2c_active) && $stable(mot_active))); // R2

    AST_IDLE_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && !reg_wdata[31]) |=> ($stable(edid_ptr) && $stable(i2c_active))); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (edid_ptr != $past(edid_ptr)) |-> (edid_ptr == PTR_W'($past(edid_ptr) + 1'b1) || edid_ptr == '0)); // R9

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        edid_ptr <= PTR_W'(EDID_BYTES)); // R10

    AST_MOT_IMPLIES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        mot_active |-> i2c_active); // R12
endmodule

bind aux_edid_responder aux_edid_checker #(
    .ADDR_W     (ADDR_W),
    .PTR_W      (PTR_W),
    .EDID_BYTES (EDID_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ctl_q      (ctl_q),
    .edid_ptr   (edid_ptr),
    .i2c_active (i2c_active),
    .mot_active (mot_active)
);

// File: tb/sim_aux_edid_responder.sv
// Sweep bench for the AUX EDID responder on a 4-port, 16-byte configuration.
module sim_aux_edid_responder;
    localparam int NP    = 4;
    localparam int NB    = 16;
    localparam int NR    = 5;
    localparam int PW    = 2;
    localparam int PTRW  = 5;
    localparam int AW    = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [PW-1:0]   port_id = '0;
    logic [NP-1:0]   port_is_dp = '0;
    logic [NP-1:0]   monitor_present = '0;
    logic [PW-1:0]   edid_port;
    logic [PTRW-1:0] edid_ptr;
    logic [7:0]      edid_byte;
    logic            i2c_active;
    logic            mot_active;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // EDID source model: byte depends on both port and pointer.
    function automatic logic [7:0] src_byte(input int p, input int k);
        return 8'((k * 13) + (p * 5) + 7);
    endfunction
    assign edid_byte = src_byte(int'(edid_port), int'(edid_ptr));

    aux_edid_responder #(.NPORTS(NP), .EDID_BYTES(NB), .NUM_REGS(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_id(port_id),
        .port_is_dp(port_is_dp), .monitor_present(monitor_present),
        .edid_port(edid_port), .edid_ptr(edid_ptr), .edid_byte(edid_byte),
        .i2c_active(i2c_active), .mot_active(mot_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    // Load a request word, then trigger with a busy control write.
    task automatic send(input logic [3:0] op, input logic [15:0] addr, input int len);
        wr(1, {op, 4'h0, addr, 8'h00});
        wr(0, 32'h8000_0000 | (32'(len) << 20));
    endtask

    function automatic logic [31:0] done_ctl(input int rs);
        return 32'h4000_0000 | (32'(rs) << 20);
    endfunction

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int exp_ptr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < NR; a++) begin
            rd(a, v); chk("R1 reg", v, 32'h0);
        end
        chk("R1 ptr", 32'(edid_ptr), 32'h0);
        chk("R1 flags", {30'h0, i2c_active, mot_active}, 32'h0);

        // R2: plain registers store and have no side effect
        for (int a = 2; a < NR; a++) begin
            wr(a, 32'hA5A5_0000 + 32'(a * 17));
            rd(a, v); chk("R2 readback", v, 32'hA5A5_0000 + 32'(a * 17));
            chk("R2 ptr", 32'(edid_ptr), 32'h0);
        end
        rd(0, v); chk("R2 ctl untouched", v, 32'h0);

        // R3: control write without busy is stored, nothing processed
        wr(1, {4'h4, 4'h0, 16'h0050, 8'h00});
        wr(0, 32'h0030_00AB);
        rd(0, v); chk("R3 ctl verbatim", v, 32'h0030_00AB);
        rd(1, v); chk("R3 data kept", v, 32'h4000_5000);
        chk("R3 flags", {30'h0, i2c_active, mot_active}, 32'h0);

        // R7 R9 R10 R4 R5: sweep ports and DP/monitor combinations
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 4; c++) begin
                port_is_dp      = c[0] ? (NP'(1) << p) : ~(NP'(1) << p);
                monitor_present = c[1] ? (NP'(1) << p) : ~(NP'(1) << p);
                port_id = PW'(p);
                send(4'h5, 16'h0050, 3);
                rd(0, v); chk("R4 start size", v, done_ctl(2));
                rd(1, v); chk("R6 start ack", v, 32'h0);
                chk("R6 flags", {30'h0, i2c_active, mot_active}, 32'h3);
                chk("R7 port", 32'(edid_port), 32'(p));
                exp_ptr = 0;
                for (int k = 0; k < NB + 2; k++) begin
                    send(4'h5, 16'h0050, 4);
                    if (c == 3 && k < NB) begin
                        rd(1, v); chk("R9 byte", v, {8'h00, src_byte(p, k), 16'h0});
                        exp_ptr = k + 1;
                    end else begin
                        rd(1, v); chk("R10 ff", v, 32'h00FF_0000);
                    end
                    chk("R9 ptr", 32'(edid_ptr), 32'(exp_ptr));
                end
                chk("R12 held", {30'h0, i2c_active, mot_active}, 32'h3);
                send(4'h1, 16'h0050, 3);
                rd(0, v); chk("R4 stop size", v, done_ctl(2));
                rd(1, v); chk("R5 stop ack", v, 32'h0);
                chk("R5 ptr", 32'(edid_ptr), 32'h0);
                chk("R5 flags", {30'h0, i2c_active, mot_active}, 32'h0);
                send(4'h5, 16'h0050, 4);
                rd(1, v); chk("R10 unselected", v, 32'h00FF_0000);
            end
        end

        // R6: address-0 start resets pointer and selection
        port_is_dp = '1; monitor_present = '1; port_id = PW'(2);
        send(4'h4, 16'h0050, 3);
        for (int k = 0; k < 3; k++) send(4'h5, 16'h0050, 4);
        chk("R9 ptr3", 32'(edid_ptr), 32'd3);
        send(4'h4, 16'h0000, 3);
        chk("R6 ptr reset", 32'(edid_ptr), 32'h0);
        chk("R6 flags set", {30'h0, i2c_active, mot_active}, 32'h3);
        send(4'h5, 16'h0050, 4);
        rd(1, v); chk("R6 deselected", v, 32'h00FF_0000);
        send(4'h4, 16'h0050, 3);
        send(4'h5, 16'h0050, 4);
        rd(1, v); chk("R7 reselect", v, {8'h00, src_byte(2, 0), 16'h0});

        // R8: write request acknowledged, data ignored
        send(4'h4, 16'h0050, 5);
        rd(0, v); chk("R8 size", v, done_ctl(1));
        rd(1, v); chk("R8 ack", v, 32'h0);
        chk("R8 ptr", 32'(edid_ptr), 32'd1);
        chk("R12 after write", {30'h0, i2c_active, mot_active}, 32'h3);

        // R11: read with bad length leaves data and pointer
        send(4'h5, 16'h0050, 6);
        rd(0, v); chk("R11 size", v, done_ctl(2));
        rd(1, v); chk("R11 data kept", v, 32'h5000_5000);
        chk("R11 ptr", 32'(edid_ptr), 32'd1);
        send(4'h5, 16'h0050, 4);
        rd(1, v); chk("R9 continues", v, {8'h00, src_byte(2, 1), 16'h0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule